// File: doc/BRIEF.md
# Reset and Wake-up Sequencer

This block sequences resets and wake-ups for a small microcontroller core. It watches an external reset input, a watchdog expiry pulse, a halt request from the core, a set of wake-up event lines and the core's interrupt request flags. From these it drives a full (cold) reset, a partial (warm) reset that only reaches the program counter and stack pointer, a halted status, and a stall that holds the core still while the oscillator settles after power-up or after leaving halt.

The cold reset is the one signal that returns the core to its initial state. That state is: program counter at address 000h, interrupts disabled, prescaler and divider cleared, timer/event counter stopped, every I/O port set as an input, and stack pointer at the top of the stack. The watchdog, real-time clock and time-base counters are cleared while cold reset is high, and the watchdog starts counting when it falls. The block also keeps two cause flags, time-out and power-down, that software reads after a restart to tell apart power-up, a pin reset while running, a pin wake from halt, a watchdog expiry while running and a watchdog wake from halt. After a wake-up caused by an event line, the core gets a resume pulse and goes on with the next instruction. After a wake-up caused by an interrupt, the block asks for interrupt entry one cycle later.

Top module: `rstwake_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, `cold_rst` and `stall` are high and both flags read 0. `stall` and `cold_rst` stay high for exactly 1024 cycles counted from the first cycle with `rst` low.
- R2: In halt, a pulse on any `wake_evt` line leaves halt. `stall` is high for exactly 1024 cycles starting the cycle after the pulse, with `cold_rst` and `warm_rst` low throughout.
- R3: An `irq_req` bit that is already 1 when the halt request is taken does not wake the block from that halt. A bit that goes from 0 to 1 during halt does wake it.
- R4: At the end of the start-up hold, an event-line wake gives one `resume_next` pulse in the first cycle with `stall` low. An interrupt wake gives no `resume_next` and gives one `irq_entry` pulse in the second cycle with `stall` low.
- R5: A `wdt_expire` pulse in halt raises `warm_rst` and `stall` together for exactly 1024 cycles, keeps `cold_rst` low, and sets time-out to 1 and power-down to 1.
- R6: A `wdt_expire` pulse while running raises `cold_rst` and `stall` for exactly one cycle, sets time-out to 1 and leaves power-down unchanged. No start-up hold follows.
- R7: `pin_rst_raw` passes through two synchronizing flops. While running, the synchronized reset makes `cold_rst` and `stall` high for as many cycles as the pin was sampled high, starting the third cycle after the pin rises. No start-up hold follows, and both flags are left unchanged.
- R8: The synchronized reset in halt raises `cold_rst` and `stall`, holds the start-up count at zero while the pin stays high, and ends the hold 1023 cycles after the pin is first seen low. The pin-high cycles plus 1023 give the total. It sets time-out to 0 and power-down to 1, and there is no `resume_next` afterwards.
- R9: Taking `halt_req` while running sets `halted`, power-down to 1 and time-out to 0. A `flags_clr` strobe while running clears both flags in the next cycle.
- R10: A `wdt_expire` pulse during the start-up hold is ignored: time-out is unchanged and the hold length is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Power-up reset, synchronous, active high |
| pin_rst_raw | input | 1 | External reset request, asynchronous, active high |
| wdt_expire | input | 1 | Watchdog expiry pulse |
| halt_req | input | 1 | Core requests halt (one-cycle strobe) |
| wake_evt | input | NWAKE | Wake-up event lines, any bit high wakes |
| irq_req | input | NIRQ | Interrupt request flags (levels) |
| flags_clr | input | 1 | Software strobe clearing both cause flags |
| cold_rst | output | 1 | Full core reset |
| warm_rst | output | 1 | Reset of program counter and stack pointer only |
| stall | output | 1 | Core held: reset or oscillator start-up |
| halted | output | 1 | Core is in halt |
| resume_next | output | 1 | Pulse: continue with the next instruction |
| irq_entry | output | 1 | Pulse: enter the interrupt service routine |
| to_flag | output | 1 | Time-out cause flag |
| pd_flag | output | 1 | Power-down cause flag |

## Verification
On every cycle the assertions check the single-cycle effects: the reset and flag result of each watchdog, pin and halt event in running and halted states, that a halt with no unmasked source stays a halt, that cold and warm reset are never both high, and where the resume and interrupt-entry pulses may fall relative to the stall. Only the bench scenarios can show the lengths of the 1024-cycle holds, including one stretched by a held pin. They also show the two-cycle synchronizer latency, the masking of an interrupt flag raised before halt across a long idle halt, and a watchdog pulse during power-up start-up that leaves the hold untouched.

// File: rtl/rwc_pkg.sv
package rwc_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_HALT,
        ST_START,
        ST_PINHOLD,
        ST_WDRST
    } seq_state_e;

    typedef enum logic [1:0] {
        RK_NONE,
        RK_COLD,
        RK_WARM
    } rst_kind_e;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_PIN_RUN,
        EV_PIN_HALT,
        EV_WDT_RUN,
        EV_WDT_HALT,
        EV_HALT,
        EV_CLR
    } flag_ev_e;

    typedef struct packed {
        logic to;
        logic pd;
    } cause_flags_t;

    // Cause-flag update for each sequencing event.
    function automatic cause_flags_t flags_next(cause_flags_t cur, flag_ev_e ev);
        cause_flags_t nxt;
        nxt = cur;
        case (ev)
            EV_PIN_HALT: begin nxt.to = 1'b0; nxt.pd = 1'b1; end
            EV_WDT_RUN:  begin nxt.to = 1'b1; end
            EV_WDT_HALT: begin nxt.to = 1'b1; nxt.pd = 1'b1; end
            EV_HALT:     begin nxt.to = 1'b0; nxt.pd = 1'b1; end
            EV_CLR:      begin nxt.to = 1'b0; nxt.pd = 1'b0; end
            default:     nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/rwc_sync.sv
module rwc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rwc_wake_detect.sv
module rwc_wake_detect #(
    parameter int NWAKE = 4,
    parameter int NIRQ  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [NWAKE-1:0] wake_evt,
    input  logic [NIRQ-1:0]  irq_req,
    output logic [NIRQ-1:0]  irq_snap,
    output logic             wake_any,
    output logic             wake_by_irq
);
    logic [NIRQ-1:0] fresh_irq;

    // Interrupt flags already pending at halt entry are masked for that halt.
    always_ff @(posedge clk) begin
        if (rst)          irq_snap <= '0;
        else if (capture) irq_snap <= irq_req;
    end

    assign fresh_irq   = irq_req & ~irq_snap;
    assign wake_by_irq = |fresh_irq;
    assign wake_any    = wake_by_irq | (|wake_evt);
endmodule

// File: rtl/rwc_startup_timer.sv
module rwc_startup_timer #(
    parameter int DELAY = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic done
);
    localparam int CW   = $clog2(DELAY);
    localparam int LAST = DELAY - 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (!done)  cnt <= cnt + 1'b1;
    end

    assign done = (cnt == CW'(LAST));
endmodule

// File: rtl/rstwake_ctrl.sv
module rstwake_ctrl
    import rwc_pkg::*;
#(
    parameter int NWAKE       = 4,
    parameter int NIRQ        = 4,
    parameter int DELAY       = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_rst_raw,
    input  logic             wdt_expire,
    input  logic             halt_req,
    input  logic [NWAKE-1:0] wake_evt,
    input  logic [NIRQ-1:0]  irq_req,
    input  logic             flags_clr,
    output logic             cold_rst,
    output logic             warm_rst,
    output logic             stall,
    output logic             halted,
    output logic             resume_next,
    output logic             irq_entry,
    output logic             to_flag,
    output logic             pd_flag
);
    seq_state_e   state, state_nx;
    rst_kind_e    kind, kind_nx;
    cause_flags_t flags;
    flag_ev_e     ev;
    logic         cause_irq, cause_irq_nx;
    logic         pin_s;
    logic         wake_any, wake_by_irq;
    logic [NIRQ-1:0] irq_snap;
    logic         timer_done, timer_clr;
    logic         start_end;
    logic         resume_q, isr_d, isr_q;

    rwc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_rst_raw),
        .q   (pin_s)
    );

    rwc_wake_detect #(.NWAKE(NWAKE), .NIRQ(NIRQ)) u_wake (
        .clk         (clk),
        .rst         (rst),
        .capture     (ev == EV_HALT),
        .wake_evt    (wake_evt),
        .irq_req     (irq_req),
        .irq_snap    (irq_snap),
        .wake_any    (wake_any),
        .wake_by_irq (wake_by_irq)
    );

    assign timer_clr = (state != ST_START) || pin_s;

    rwc_startup_timer #(.DELAY(DELAY)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .clr  (timer_clr),
        .done (timer_done)
    );

    // Sequencing: pin reset over watchdog over halt over flag clear.
    always_comb begin
        state_nx     = state;
        kind_nx      = kind;
        cause_irq_nx = cause_irq;
        ev           = EV_NONE;
        start_end    = 1'b0;
        case (state)
            ST_RUN: begin
                if (pin_s) begin
                    state_nx = ST_PINHOLD;
                    ev       = EV_PIN_RUN;
                end else if (wdt_expire) begin
                    state_nx = ST_WDRST;
                    ev       = EV_WDT_RUN;
                end else if (halt_req) begin
                    state_nx = ST_HALT;
                    ev       = EV_HALT;
                end else if (flags_clr) begin
                    ev       = EV_CLR;
                end
            end
            ST_HALT: begin
                if (pin_s) begin
                    state_nx     = ST_START;
                    kind_nx      = RK_COLD;
                    cause_irq_nx = 1'b0;
                    ev           = EV_PIN_HALT;
                end else if (wdt_expire) begin
                    state_nx     = ST_START;
                    kind_nx      = RK_WARM;
                    cause_irq_nx = 1'b0;
                    ev           = EV_WDT_HALT;
                end else if (wake_any) begin
                    state_nx     = ST_START;
                    kind_nx      = RK_NONE;
                    cause_irq_nx = wake_by_irq;
                end
            end
            ST_START: begin
                if (pin_s) begin
                    kind_nx = RK_COLD;
                end else if (timer_done) begin
                    state_nx  = ST_RUN;
                    start_end = 1'b1;
                end
            end
            ST_PINHOLD: begin
                if (!pin_s) state_nx = ST_RUN;
            end
            ST_WDRST: begin
                state_nx = pin_s ? ST_PINHOLD : ST_RUN;
            end
            default: state_nx = ST_START;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_START;
            kind      <= RK_COLD;
            cause_irq <= 1'b0;
            flags     <= '0;
            resume_q  <= 1'b0;
            isr_d     <= 1'b0;
            isr_q     <= 1'b0;
        end else begin
            state     <= state_nx;
            kind      <= kind_nx;
            cause_irq <= cause_irq_nx;
            flags     <= flags_next(flags, ev);
            resume_q  <= start_end && (kind == RK_NONE) && !cause_irq;
            isr_d     <= start_end && (kind == RK_NONE) && cause_irq;
            isr_q     <= isr_d;
        end
    end

    assign cold_rst    = ((state == ST_START) && (kind == RK_COLD)) ||
                         (state == ST_PINHOLD) || (state == ST_WDRST);
    assign warm_rst    = (state == ST_START) && (kind == RK_WARM);
    assign stall       = (state == ST_START) || (state == ST_PINHOLD) ||
                         (state == ST_WDRST);
    assign halted      = (state == ST_HALT);
    assign resume_next = resume_q;
    assign irq_entry   = isr_q;
    assign to_flag     = flags.to;
    assign pd_flag     = flags.pd;
endmodule

// File: rtl/rwc_chk.sv
module rwc_chk #(
    parameter int NWAKE = 4,
    parameter int NIRQ  = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             pin_s,
    input logic [NIRQ-1:0]  irq_snap,
    input logic             wdt_expire,
    input logic             halt_req,
    input logic [NWAKE-1:0] wake_evt,
    input logic [NIRQ-1:0]  irq_req,
    input logic             cold_rst,
    input logic             warm_rst,
    input logic             stall,
    input logic             halted,
    input logic             resume_next,
    input logic             irq_entry,
    input logic             to_flag,
    input logic             pd_flag
);
    logic rst_d;
    logic running;

    assign running = !halted && !stall;

    always_ff @(posedge clk) rst_d <= rst;

    // R1
    always_ff @(posedge clk) begin
        if (rst_d) begin
            pwrup_state_chk: assert (cold_rst && stall && !to_flag && !pd_flag)
                else $error("power-up state wrong");
        end
    end

    // R5
    cold_warm_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(cold_rst && warm_rst));

    // R3
    masked_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (halted && !pin_s && !wdt_expire && (wake_evt == '0) &&
         ((irq_req & ~irq_snap) == '0)) |=> halted);

    // R4
    resume_pos_chk: assert property (@(posedge clk) disable iff (rst)
        resume_next |-> ($past(stall) && !stall && !irq_entry));

    // R4
    isr_pos_chk: assert property (@(posedge clk) disable iff (rst)
        irq_entry |-> (!$past(stall) && $past(stall, 2)));

    // R5
    wdt_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (halted && !pin_s && wdt_expire) |=>
        (warm_rst && stall && !cold_rst && to_flag && pd_flag));

    // R6
    wdt_run_chk: assert property (@(posedge clk) disable iff (rst)
        (running && !pin_s && wdt_expire) |=>
        (cold_rst && stall && to_flag && $stable(pd_flag)));

    // R7
    pin_run_chk: assert property (@(posedge clk) disable iff (rst)
        (running && pin_s) |=>
        (cold_rst && stall && $stable(to_flag) && $stable(pd_flag)));

    // R8
    pin_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (halted && pin_s) |=> (cold_rst && stall && pd_flag && !to_flag));

    // R9
    halt_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (running && !pin_s && !wdt_expire && halt_req) |=>
        (halted && pd_flag && !to_flag));
endmodule

bind rstwake_ctrl rwc_chk #(.NWAKE(NWAKE), .NIRQ(NIRQ)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pin_s       (pin_s),
    .irq_snap    (irq_snap),
    .wdt_expire  (wdt_expire),
    .halt_req    (halt_req),
    .wake_evt    (wake_evt),
    .irq_req     (irq_req),
    .cold_rst    (cold_rst),
    .warm_rst    (warm_rst),
    .stall       (stall),
    .halted      (halted),
    .resume_next (resume_next),
    .irq_entry   (irq_entry),
    .to_flag     (to_flag),
    .pd_flag     (pd_flag)
);

// File: tb/rstwake_ctrl_bench.sv
module rstwake_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NWAKE = 4;
    localparam int NIRQ  = 4;
    localparam int HOLD  = 1024;
    localparam int LIMIT = 150000;

    logic             clk = 1'b0;
    logic             rst;
    logic             pin_rst_raw;
    logic             wdt_expire;
    logic             halt_req;
    logic [NWAKE-1:0] wake_evt;
    logic [NIRQ-1:0]  irq_req;
    logic             flags_clr;
    logic cold_rst, warm_rst, stall, halted, resume_next, irq_entry, to_flag, pd_flag;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    int st_cnt;
    bit st_cold, st_warm, st_allcold, st_allwarm;

    always #(CLK_PERIOD/2) clk = ~clk;

    rstwake_ctrl #(.NWAKE(NWAKE), .NIRQ(NIRQ), .DELAY(HOLD)) u_rstwake_ctrl (
        .clk(clk), .rst(rst), .pin_rst_raw(pin_rst_raw), .wdt_expire(wdt_expire),
        .halt_req(halt_req), .wake_evt(wake_evt), .irq_req(irq_req),
        .flags_clr(flags_clr), .cold_rst(cold_rst), .warm_rst(warm_rst),
        .stall(stall), .halted(halted), .resume_next(resume_next),
        .irq_entry(irq_entry), .to_flag(to_flag), .pd_flag(pd_flag)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > LIMIT) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, LIMIT);
            report();
        end
    end

    // Counts stall-high samples starting at the current negedge.
    task automatic count_stall;
        st_cnt = 0; st_cold = 0; st_warm = 0; st_allcold = 1; st_allwarm = 1;
        while (stall && st_cnt < 5000) begin
            st_cnt++;
            if (cold_rst) st_cold = 1; else st_allcold = 0;
            if (warm_rst) st_warm = 1; else st_allwarm = 0;
            @(negedge clk);
        end
    endtask

    task automatic do_halt;
        halt_req = 1'b1;
        @(negedge clk);
        halt_req = 1'b0;
    endtask

    task automatic t_powerup;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check("R1", "cold_rst in reset", cold_rst, 1);
        check("R1", "stall in reset", stall, 1);
        check("R1", "to_flag in reset", to_flag, 0);
        check("R1", "pd_flag in reset", pd_flag, 0);
        rst = 1'b0;
        st_cnt = 0; st_allcold = 1;
        while (stall && st_cnt < 5000) begin
            st_cnt++;
            if (!cold_rst) st_allcold = 0;
            wdt_expire = (st_cnt == 100);
            @(negedge clk);
        end
        wdt_expire = 1'b0;
        check("R1", "power-up hold length", st_cnt, HOLD);
        check("R1", "cold_rst through hold", st_allcold, 1);
        check("R10", "to_flag after ignored watchdog", to_flag, 0);
        check("R1", "halted after power-up", halted, 0);
    endtask

    task automatic t_halt_event;
        do_halt();
        check("R9", "halted after request", halted, 1);
        check("R9", "pd_flag after halt", pd_flag, 1);
        check("R9", "to_flag after halt", to_flag, 0);
        repeat (20) @(negedge clk);
        check("R2", "stays halted without wake", halted, 1);
        wake_evt = 4'b0100;
        @(negedge clk);
        wake_evt = '0;
        count_stall();
        check("R2", "event wake hold length", st_cnt, HOLD);
        check("R2", "no cold reset on event wake", st_cold, 0);
        check("R2", "no warm reset on event wake", st_warm, 0);
        check("R4", "resume pulse after event wake", resume_next, 1);
        check("R4", "no irq entry after event wake", irq_entry, 0);
        @(negedge clk);
        check("R4", "resume pulse one cycle", resume_next, 0);
        check("R4", "no late irq entry", irq_entry, 0);
    endtask

    task automatic t_irq_mask;
        irq_req = 4'b0001;
        @(negedge clk);
        do_halt();
        repeat (30) @(negedge clk);
        check("R3", "pending irq does not wake", halted, 1);
        irq_req = 4'b0011;
        @(negedge clk);
        check("R3", "new irq wakes", halted, 0);
        count_stall();
        check("R3", "irq wake hold length", st_cnt, HOLD);
        check("R4", "no resume on irq wake", resume_next, 0);
        check("R4", "irq entry not yet", irq_entry, 0);
        @(negedge clk);
        check("R4", "irq entry second cycle", irq_entry, 1);
        @(negedge clk);
        check("R4", "irq entry one cycle", irq_entry, 0);
        irq_req = '0;
    endtask

    task automatic t_wdt_halt;
        do_halt();
        wdt_expire = 1'b1;
        @(negedge clk);
        wdt_expire = 1'b0;
        check("R5", "to_flag after watchdog wake", to_flag, 1);
        check("R5", "pd_flag after watchdog wake", pd_flag, 1);
        count_stall();
        check("R5", "warm hold length", st_cnt, HOLD);
        check("R5", "warm_rst through hold", st_allwarm, 1);
        check("R5", "cold_rst low in warm hold", st_cold, 0);
        check("R5", "no resume after warm reset", resume_next, 0);
    endtask

    task automatic t_clear;
        flags_clr = 1'b1;
        @(negedge clk);
        flags_clr = 1'b0;
        check("R9", "to_flag cleared", to_flag, 0);
        check("R9", "pd_flag cleared", pd_flag, 0);
    endtask

    task automatic t_wdt_run;
        wdt_expire = 1'b1;
        @(negedge clk);
        wdt_expire = 1'b0;
        check("R6", "cold_rst on run watchdog", cold_rst, 1);
        check("R6", "stall on run watchdog", stall, 1);
        check("R6", "to_flag set", to_flag, 1);
        check("R6", "pd_flag unchanged", pd_flag, 0);
        @(negedge clk);
        check("R6", "cold_rst one cycle", cold_rst, 0);
        check("R6", "no start-up hold", stall, 0);
    endtask

    task automatic t_pin_run;
        int first = -1;
        int highs = 0;
        int colds = 0;
        pin_rst_raw = 1'b1;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            if (i == 4) pin_rst_raw = 1'b0;
            if (stall) begin
                highs++;
                if (first < 0) first = i;
            end
            if (cold_rst) colds++;
        end
        check("R7", "sync latency", first, 2);
        check("R7", "pin hold length", highs, 5);
        check("R7", "cold_rst length", colds, 5);
        check("R7", "to_flag unchanged", to_flag, 1);
        check("R7", "pd_flag unchanged", pd_flag, 0);
    endtask

    task automatic t_pin_halt;
        do_halt();
        pin_rst_raw = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (i == 2) pin_rst_raw = 1'b0;
        end
        count_stall();
        check("R8", "pin wake hold length", st_cnt, 3 + HOLD - 1);
        check("R8", "cold_rst through hold", st_allcold, 1);
        check("R8", "to_flag after pin wake", to_flag, 0);
        check("R8", "pd_flag after pin wake", pd_flag, 1);
        check("R8", "no resume after pin wake", resume_next, 0);
        check("R8", "running again", halted, 0);
    endtask

    initial begin
        rst = 1'b1; pin_rst_raw = 1'b0; wdt_expire = 1'b0; halt_req = 1'b0;
        wake_evt = '0; irq_req = '0; flags_clr = 1'b0;
        @(negedge clk);
        t_powerup();
        repeat (3) @(negedge clk);
        t_halt_event();
        t_irq_mask();
        t_wdt_halt();
        t_clear();
        t_wdt_run();
        repeat (2) @(negedge clk);
        t_pin_run();
        t_pin_halt();
        repeat (2) @(negedge clk);
        report();
    end
endmodule